// File: doc/BRIEF.md
# Armed-Reload Watchdog Timer

An 8-bit watchdog for a small microcontroller. A fixed two-stage prescaler divides the system clock into ticks (by default 12 × 2048 clocks per tick). Each tick moves an upward counter one step. When the counter rolls over from FFh to 00h, the block drives a pulse of fixed length on its internal reset output. The pulse also returns the block's own state to its reset values.

Software keeps the system alive by writing a reload value before the counter rolls over. A write is accepted only after a separate control write has armed a one-shot load-enable flag. Each accepted load uses up the flag and clears the prescaler. The time from a load of value V to the reset is therefore exactly (256 − V) full tick periods. An enable bit starts and stops the watchdog. While it is set, power-down requests are refused. Idle mode does not affect the watchdog.

The register-write and control inputs are single-cycle strobes with no handshake. Every strobe is taken in the cycle it is presented, so there is no back-pressure at any pin.

Top module: `wdog_guard`

## Requirements
- R1: The 8-bit counter counts upward by one on each tick. While `en` is 1, a tick occurs once every PRE_A × PRE_B clocks. After an accepted load of value V, the first rising clock edge with `wd_rst` high is exactly (256 − V) × PRE_A × PRE_B edges after the load edge. FFh gives 1 tick and 00h gives 256 ticks.
- R2: A strobe on `reload_wr` while the load-enable flag is 0 is ignored. It changes neither the counter, the prescaler nor the flag.
- R3: A pulse on `arm_set` sets the load-enable flag. An accepted load clears it, so each reload needs a new arm. When `arm_set` and `reload_wr` arrive in the same cycle, the write is judged against the flag's old value and the flag ends up set.
- R4: An accepted load clears the prescaler, so the first tick after a load comes a full PRE_A × PRE_B clocks later, whatever the prescaler's phase was before the load.
- R5: With `en` at 0, the counter and the prescaler hold their values. Loads are still accepted. Setting `en` back to 1 resumes the count from where it stopped.
- R6: On the tick that rolls the counter from FFh to 00h, `wd_rst` goes high from the next clock edge and stays high for exactly RST_LEN cycles (default 24). While `wd_rst` is high, the counter, the prescaler and the flag are held at zero, and `arm_set` and `reload_wr` are ignored.
- R7: `pd_grant` equals `pd_req` AND NOT `en`, combinationally.
- R8: `idle_req` has no effect. The watchdog counts and can assert `wd_rst` while idle is requested.
- R9: `rst_n` low clears the counter, the prescaler, the flag and `wd_rst` asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| arm_set | input | 1 | Control-write strobe that sets the load-enable flag |
| reload_wr | input | 1 | Reload-register write strobe |
| reload_val | input | CNT_W | Reload value that goes with `reload_wr` |
| en | input | 1 | Watchdog enable bit |
| idle_req | input | 1 | Idle mode request (no effect on the watchdog) |
| pd_req | input | 1 | Power-down request |
| pd_grant | output | 1 | Power-down permitted and requested |
| wd_rst | output | 1 | Internal reset pulse issued on overflow |

## Verification
The reload is tried with the extreme values FFh and 00h and with a middle value. Counting the edges to the reset tells apart an off-by-one in the tick, an off-by-one in the overflow and a wrong count direction. Further runs load after the prescaler has advanced, write without arming, repeat a write after the flag has been used, and arm and write in the same cycle. These separate a missing prescaler clear, a flag that fails to gate writes, a flag that fails to clear itself, and the wrong priority between arm and load. Pausing `en` in the middle of a countdown, holding `idle_req`, and pulsing `arm_set` and `rst_n` during the reset pulse show that the count freezes and resumes, that idle has no effect, and that the pulse leaves the state clean. A reference model compares `wd_rst` and `pd_grant` on every cycle.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // events exchanged between the counter core and the pulse stretcher
  typedef struct packed {
    logic load;   // accepted reload this cycle
    logic tick;   // prescaler terminal count this cycle
    logic ovf;    // counter wraps to zero this cycle
  } wd_evt_t;

  function automatic int unsigned cnt_bits(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/wdog_stage.sv
module wdog_stage #(
  parameter int unsigned DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic step_in,
  output logic carry
);
  localparam int unsigned W = wdog_pkg::cnt_bits(DIV);

  generate
    if (DIV <= 1) begin : g_pass
      assign carry = step_in;
      logic unused_stage;
      assign unused_stage = clr;
    end else begin : g_div
      logic [W-1:0] q;
      logic         at_top;
      assign at_top = (q == W'(DIV - 1));
      assign carry  = step_in & at_top;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        q <= '0;
        else if (clr)      q <= '0;
        else if (step_in)  q <= at_top ? '0 : q + W'(1);
      end
    end
  endgenerate
endmodule

// File: rtl/wdog_prescale.sv
module wdog_prescale #(
  parameter int unsigned PRE_A = 12,
  parameter int unsigned PRE_B = 2048
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic run,
  output logic tick
);
  logic carry_a;

  wdog_stage #(.DIV(PRE_A)) u_fixed (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step_in(run), .carry(carry_a)
  );

  wdog_stage #(.DIV(PRE_B)) u_wide (
    .clk(clk), .rst_n(rst_n), .clr(clr), .step_in(carry_a), .carry(tick)
  );
endmodule

// File: rtl/wdog_core.sv
module wdog_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sys_clr,
  input  logic             arm_set,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             tick,
  output wdog_pkg::wd_evt_t evt,
  output logic             flag_q,
  output logic [CNT_W-1:0] cnt_q
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic load;
  assign load     = reload_wr & flag_q & ~sys_clr;
  assign evt.load = load;
  assign evt.tick = tick & ~load;
  assign evt.ovf  = tick & ~load & (cnt_q == TOP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else if (sys_clr) begin
      cnt_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (load)      cnt_q <= reload_val;
      else if (tick) cnt_q <= cnt_q + ONE;
      if (arm_set)   flag_q <= 1'b1;
      else if (load) flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/wdog_stretch.sv
module wdog_stretch #(
  parameter int unsigned RST_LEN = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ovf,
  output logic pulse
);
  localparam int unsigned SW = wdog_pkg::cnt_bits(RST_LEN + 1);
  logic [SW-1:0] left;

  assign pulse = (left != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      left <= '0;
    else if (pulse)  left <= left - SW'(1);
    else if (ovf)    left <= SW'(RST_LEN);
  end
endmodule

// File: rtl/wdog_guard.sv
module wdog_guard #(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned PRE_A   = 12,
  parameter int unsigned PRE_B   = 2048,
  parameter int unsigned RST_LEN = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm_set,
  input  logic             reload_wr,
  input  logic [CNT_W-1:0] reload_val,
  input  logic             en,
  input  logic             idle_req,
  input  logic             pd_req,
  output logic             pd_grant,
  output logic             wd_rst
);
  wdog_pkg::wd_evt_t evt;
  logic             tick;
  logic             flag_q;
  logic [CNT_W-1:0] cnt_q;
  logic             pre_clr;

  // idle mode leaves the watchdog running
  logic unused_idle;
  assign unused_idle = idle_req;

  assign pd_grant = pd_req & ~en;
  assign pre_clr  = evt.load | wd_rst;

  wdog_prescale #(.PRE_A(PRE_A), .PRE_B(PRE_B)) u_pre (
    .clk(clk), .rst_n(rst_n), .clr(pre_clr), .run(en), .tick(tick)
  );

  wdog_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst_n(rst_n), .sys_clr(wd_rst), .arm_set(arm_set),
    .reload_wr(reload_wr), .reload_val(reload_val), .tick(tick),
    .evt(evt), .flag_q(flag_q), .cnt_q(cnt_q)
  );

  wdog_stretch #(.RST_LEN(RST_LEN)) u_str (
    .clk(clk), .rst_n(rst_n), .ovf(evt.ovf), .pulse(wd_rst)
  );
endmodule

// File: rtl/wdog_guard_chk.sv
module wdog_guard_chk #(
  parameter int unsigned CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             en,
  input logic             pd_grant,
  input logic             arm_set,
  input logic             reload_wr,
  input logic             wd_rst,
  input logic             flag_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             load
);
  // R7
  en_blocks_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> !pd_grant);

  // R3
  flag_spent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !arm_set) |=> !flag_q);

  // R2
  unarmed_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_wr && !flag_q && !en && !wd_rst) |=> $stable(cnt_q));

  // R5
  frozen_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !load && !wd_rst) |=> $stable(cnt_q));

  // R6
  rise_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wd_rst) |-> ($past(cnt_q) == {CNT_W{1'b1}}));

  // R6
  clean_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> (!flag_q && cnt_q == '0));
endmodule

bind wdog_guard wdog_guard_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .pd_grant(pd_grant),
  .arm_set(arm_set), .reload_wr(reload_wr), .wd_rst(wd_rst),
  .flag_q(flag_q), .cnt_q(cnt_q), .load(evt.load)
);

// File: tb/tb_wdog_guard.sv
module tb_wdog_guard;
  localparam int PA = 3, PB = 4, DIV = PA * PB, RL = 24;

  logic clk = 0, rst_n = 0, arm_set = 0, reload_wr = 0;
  logic en = 0, idle_req = 0, pd_req = 0;
  logic [7:0] reload_val = '0;
  logic pd_grant, wd_rst;

  int n_total = 0, n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  wdog_guard #(.CNT_W(8), .PRE_A(PA), .PRE_B(PB), .RST_LEN(RL)) dut (
    .clk(clk), .rst_n(rst_n), .arm_set(arm_set), .reload_wr(reload_wr),
    .reload_val(reload_val), .en(en), .idle_req(idle_req), .pd_req(pd_req),
    .pd_grant(pd_grant), .wd_rst(wd_rst)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_total++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // behavioural reference: counter, phase and pulse budget as integers
  int m_cnt = 0, m_phase = 0, m_left = 0;
  bit m_flag = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_phase = 0; m_left = 0; m_flag = 0;
    end else if (m_left > 0) begin
      m_left--; m_cnt = 0; m_phase = 0; m_flag = 0;
    end else begin
      bit take;
      take = reload_wr && m_flag;
      if (take) begin
        m_cnt = reload_val; m_phase = 0;
      end else if (en) begin
        m_phase++;
        if (m_phase == DIV) begin
          m_phase = 0;
          m_cnt++;
          if (m_cnt == 256) begin m_cnt = 0; m_left = RL; end
        end
      end
      if (arm_set) m_flag = 1;
      else if (take) m_flag = 0;
    end
  end

  always @(negedge clk) if (rst_n && !done) begin
    chk(wd_rst == (m_left > 0), "R6 model", wd_rst, m_left > 0);
    chk(pd_grant == (pd_req && !en), "R7 model", pd_grant, pd_req && !en);
  end

  // all tasks start just after a falling edge
  task automatic arm();
    arm_set = 1; @(negedge clk); arm_set = 0;
  endtask

  task automatic wr(input logic [7:0] v);
    reload_val = v; reload_wr = 1; @(negedge clk); reload_wr = 0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic measure(input int exp, input string req);
    int n = 0;
    do begin @(negedge clk); n++; end while (!wd_rst && n < 5000);
    chk(n == exp, req, n, exp);
  endtask

  task automatic pulse_len();
    int n = 0;
    while (wd_rst && n < 1000) begin @(negedge clk); n++; end
    en = 0;
    chk(n == RL, "R6 pulse length", n, RL);
  endtask

  initial begin
    wait_n(3);
    rst_n = 1;
    #1;
    chk(wd_rst == 0, "R9 reset state", wd_rst, 0);
    chk(pd_grant == 0, "R9 reset pd_grant", pd_grant, 0);
    @(negedge clk);

    // R1: FFh gives one tick; arm during the pulse must be ignored (R6)
    en = 1; arm(); wr(8'hFF);
    measure(DIV, "R1 reload FF");
    begin
      int n = 1;
      arm_set = 1; @(negedge clk); arm_set = 0;
      while (wd_rst && n < 1000) begin @(negedge clk); n++; end
      en = 0;
      chk(n == RL, "R6 pulse length with arm", n, RL);
    end

    // R2: unarmed write ignored (flag cleared by pulse, counter at 00h)
    wr(8'hFF); en = 1;
    measure(256 * DIV, "R2 unarmed write ignored");
    pulse_len();

    // R1: 00h gives 256 ticks
    en = 1; arm(); wr(8'h00);
    measure(256 * DIV, "R1 reload 00");
    pulse_len();

    // R3: second write after the flag was spent is ignored
    en = 1; arm(); wr(8'hF0); wr(8'hFF);
    measure(16 * DIV - 1, "R3 one-shot flag");
    pulse_len();

    // R4: load after the prescaler advanced restarts the phase
    en = 1; wait_n(5); arm(); wr(8'hFF);
    measure(DIV, "R4 prescaler cleared");
    pulse_len();

    // R3: arm and write together; write refused, flag set for the next
    reload_val = 8'hFF; arm_set = 1; reload_wr = 1; @(negedge clk);
    arm_set = 0; reload_wr = 0;
    wr(8'hFE); en = 1;
    measure(2 * DIV, "R3 arm with write");
    pulse_len();

    // R5 and R7: pause in the middle of a countdown
    arm(); wr(8'hFE); en = 1; wait_n(10); en = 0; pd_req = 1;
    #1 chk(pd_grant == 1, "R7 grant when disabled", pd_grant, 1);
    wait_n(100);
    chk(wd_rst == 0, "R5 frozen while disabled", wd_rst, 0);
    en = 1;
    #1 chk(pd_grant == 0, "R7 blocked when enabled", pd_grant, 0);
    pd_req = 0;
    measure(2 * DIV - 10, "R5 resume count");
    pulse_len();

    // R8: idle request does not stop the watchdog
    idle_req = 1; en = 1; arm(); wr(8'hFF);
    measure(DIV, "R8 idle keeps counting");
    pulse_len();
    idle_req = 0;

    // R9: asynchronous reset during the pulse
    en = 1; arm(); wr(8'hFF);
    measure(DIV, "R1 before async reset");
    #3 rst_n = 0;
    #1 chk(wd_rst == 0, "R9 async clear", wd_rst, 0);
    en = 0;
    @(negedge clk); rst_n = 1;
    wait_n(3);
    chk(wd_rst == 0, "R9 stays clear", wd_rst, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_total++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end
endmodule